// File: doc/BRIEF.md
# External Interrupt Request Controller

This block keeps one processor's word of pending external interrupt requests and the matching enable mask, and decides at each interrupt poll whether the processor should take an interrupt. Any agent on the system bus raises a request by writing a 4-byte word to the block's bus slot. The written value does not land in the register. Instead, the bitwise inverse of its low bits names one request bit, counted from the most significant end, and the block sets that bit. An internal alarm timer raises request 0 the same way. The processor clears requests with write-one-to-clear control writes and loads the enable mask through its own control port.

The request word is 32 bits wide, or 64 bits when the core supports the wide architecture and its default status has the wide bit set. A level output reports whether any request is pending. When the processor polls, the block picks between a latched non-maskable transfer-of-control request and an enabled maskable request. The non-maskable request goes first. The result is a one-cycle pulse that carries the exception code.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the request word, the enable mask and the non-maskable flag are zero, `irq_pending` is low and `take_valid` is low.
- R2: A bus write with `bus_size` equal to 4 sets the register bit at index (bitwise NOT of `bus_wdata`) AND (W-1), with bit 0 as the least significant bit and W the active width. Writing n therefore sets bit W-1-(n mod W): writing 0 sets bit W-1, and in 32-bit mode writing 5 or 37 sets bit 26. Other bits do not change.
- R3: The active width W is 64 only when `cfg_arch_wide` and `cfg_wide_default` are both 1. Otherwise it is 32.
- R4: A bus write whose `bus_size` is not 4 changes nothing. `bus_rdata` shows the whole request word while `bus_rd_en` is high and `bus_size` is 4, and shows zero otherwise.
- R5: A clear write (`cpu_clr_en`) zeroes every request bit that is 1 in `cpu_clr_mask` and leaves the other bits alone.
- R6: When a set and a clear hit the same bit in one cycle, the clear is applied first and then the set, so the bit ends up 1.
- R7: `irq_pending` is high exactly when the request word is non-zero. It follows each set or clear one clock after the write.
- R8: A `tmr_alarm` pulse has the same effect as a size-4 bus write of data 0, setting bit W-1. An alarm and a bus write in the same cycle both take effect.
- R9: On a poll cycle with the non-maskable flag clear, the cycle after the poll carries `take_valid` with `take_code` 4 if and only if `psw_ien` is 1 and the request word AND the enable mask (loaded by `cpu_mask_we`) is non-zero.
- R10: A `nmi_req` pulse latches a flag. The next poll takes it before any maskable request, whatever `psw_ien` is, with `take_code` 33, and clears the flag unless a new `nmi_req` arrives in the same cycle.
- R11: `take_valid` is high only in the cycle right after a poll. Without `cpu_poll` no interrupt is taken, and `take_code` is 0 whenever `take_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_arch_wide | input | 1 | Core supports the wide architecture |
| cfg_wide_default | input | 1 | Wide bit of the default status word |
| bus_wr_en | input | 1 | Bus write strobe to the request slot |
| bus_rd_en | input | 1 | Bus read strobe to the request slot |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Bus write data (selects the bit to set) |
| bus_rdata | output | 64 | Request word on a valid read, else zero |
| tmr_alarm | input | 1 | Alarm timer event (raises request 0) |
| cpu_clr_en | input | 1 | Processor clear write strobe |
| cpu_clr_mask | input | 64 | Bits to clear |
| cpu_mask_we | input | 1 | Enable mask write strobe |
| cpu_mask_wdata | input | 64 | New enable mask |
| psw_ien | input | 1 | Interrupt enable bit of the processor status |
| nmi_req | input | 1 | Non-maskable transfer-of-control request pulse |
| cpu_poll | input | 1 | Processor asks for an interrupt decision |
| irq_pending | output | 1 | Some request bit is set |
| take_valid | output | 1 | One-cycle pulse: an interrupt is taken |
| take_code | output | 6 | Exception code of the taken interrupt |

## Verification
The bit-select decoding is tried with data 0, small values and values at or above the width, in both widths and in every combination of the two width controls. This separates a correct inverted, masked index from a non-inverted index, from a missing mask and from a wide mode enabled by one control alone. Colliding set/clear pairs, alarm-plus-write cycles and wrong-size accesses show whether the clear is applied before the set, whether simultaneous sources merge and whether the size filter is present. A long random stream of polls with mixed enables, masks and non-maskable pulses, checked every cycle against a bench model, separates the correct priority and flag-clearing from swapped priority, a sticky flag or a decision that ignores the mask or the enable bit.

// File: rtl/ext_irq_pkg.sv
// Package: shared exception codes and the take-decision kind for the
// external interrupt request controller.
package ext_irq_pkg;

    typedef logic [5:0] exc_code_t;

    // Code carried by a maskable external interrupt.
    localparam exc_code_t EXC_EXTERNAL = 6'd4;
    // Code carried by a non-maskable transfer of control.
    localparam exc_code_t EXC_XFER_CTL = 6'd33;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_EXT  = 2'd1,
        TAKE_TOC  = 2'd2
    } take_kind_e;

endpackage

// File: rtl/ext_irq_bitsel.sv
// Module: ext_irq_bitsel
// Turns a bus write word and an alarm event into a one-hot-or-two set vector.
// The bit to set is the inverted low bits of the data, masked to the active
// width; the alarm always targets the top bit of the active width.
// Assumes wr_hit already includes the access-size check, and that the
// data word is at least as wide as the wide-mode index.
module ext_irq_bitsel #(
    parameter int MAX_W    = 64,
    parameter int NARROW_W = 32,
    parameter int IDX_SRC  = 6
) (
    input  logic               wide_sel,
    input  logic               wr_hit,
    input  logic [IDX_SRC-1:0] wr_low,
    input  logic               alarm,
    output logic [MAX_W-1:0]   set_vec
);

    localparam int IDX_W  = $clog2(MAX_W);
    localparam int NIDX_W = $clog2(NARROW_W);

    logic [IDX_W-1:0]  wide_idx;
    logic [NIDX_W-1:0] narrow_idx;
    logic [IDX_W-1:0]  idx_sel;
    logic [IDX_W-1:0]  top_idx;

    // Invert the low data bits for each width, then choose one.
    always_comb begin
        wide_idx   = ~wr_low[IDX_W-1:0];
        narrow_idx = ~wr_low[NIDX_W-1:0];
        idx_sel    = wide_sel ? wide_idx : IDX_W'(narrow_idx);
        top_idx    = wide_sel ? IDX_W'(MAX_W - 1) : IDX_W'(NARROW_W - 1);
    end

    // One decode comparator per request bit.
    for (genvar b = 0; b < MAX_W; b++) begin : g_dec
        assign set_vec[b] = (wr_hit && (idx_sel == IDX_W'(b)))
                         || (alarm  && (top_idx == IDX_W'(b)));
    end

endmodule

// File: rtl/ext_irq_reqreg.sv
// Module: ext_irq_reqreg
// Holds the request word and the enable mask. A clear is applied before a
// set in the same cycle so a fresh request is never lost. The pending level
// is derived from the stored word.
// Assumes set_vec and clr_mask are already qualified by their strobes.
module ext_irq_reqreg #(
    parameter int MAX_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAX_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [MAX_W-1:0] clr_mask,
    input  logic             mask_we,
    input  logic [MAX_W-1:0] mask_wdata,
    output logic [MAX_W-1:0] req_q,
    output logic [MAX_W-1:0] mask_q,
    output logic             pending
);

    logic [MAX_W-1:0] clr_eff;
    logic [MAX_W-1:0] req_d;

    // Next request word: clear first, then merge new sets.
    always_comb begin
        clr_eff = clr_en ? clr_mask : '0;
        req_d   = (req_q & ~clr_eff) | set_vec;
    end

    // Request word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    // Enable mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Pending level reflects the stored word.
    assign pending = |req_q;

endmodule

// File: rtl/ext_irq_arb.sv
// Module: ext_irq_arb
// Latches the non-maskable request and, on each poll, chooses between it
// and an enabled maskable request. Emits a registered one-cycle pulse with
// the exception code. Assumes req and mask are the stored register values.
module ext_irq_arb
    import ext_irq_pkg::*;
#(
    parameter int MAX_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll,
    input  logic             nmi_req,
    input  logic             ien,
    input  logic [MAX_W-1:0] req,
    input  logic [MAX_W-1:0] mask,
    output logic             nmi_flag_q,
    output logic             take_valid,
    output exc_code_t        take_code
);

    take_kind_e kind;
    logic       maskable_hit;
    logic       nmi_taken;

    // Priority pick: non-maskable first, then enabled maskable.
    always_comb begin
        maskable_hit = ien && (|(req & mask));
        kind         = TAKE_NONE;
        if (poll) begin
            if (nmi_flag_q)        kind = TAKE_TOC;
            else if (maskable_hit) kind = TAKE_EXT;
        end
        nmi_taken = (kind == TAKE_TOC);
    end

    // Non-maskable flag: set by a request, dropped when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_flag_q <= 1'b0;
        else        nmi_flag_q <= nmi_req || (nmi_flag_q && !nmi_taken);
    end

    // Registered take pulse and its code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid <= 1'b0;
            take_code  <= '0;
        end else begin
            take_valid <= (kind != TAKE_NONE);
            case (kind)
                TAKE_TOC: take_code <= EXC_XFER_CTL;
                TAKE_EXT: take_code <= EXC_EXTERNAL;
                default:  take_code <= '0;
            endcase
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: ext_irq_ctrl (top)
// Per-processor external interrupt request controller. Selects the active
// width, filters bus accesses by size, decodes the set bit, keeps the
// request word and mask, and makes the take decision on each poll.
// Assumes all inputs are synchronous to clk.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int MAX_W     = 64,
    parameter int NARROW_W  = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int ACC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_arch_wide,
    input  logic              cfg_wide_default,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [MAX_W-1:0]  bus_rdata,
    input  logic              tmr_alarm,
    input  logic              cpu_clr_en,
    input  logic [MAX_W-1:0]  cpu_clr_mask,
    input  logic              cpu_mask_we,
    input  logic [MAX_W-1:0]  cpu_mask_wdata,
    input  logic              psw_ien,
    input  logic              nmi_req,
    input  logic              cpu_poll,
    output logic              irq_pending,
    output logic              take_valid,
    output logic [5:0]        take_code
);

    localparam int IDX_W = $clog2(MAX_W);

    logic             wide_sel;
    logic             size_ok;
    logic             wr_hit;
    logic [MAX_W-1:0] set_vec;
    logic [MAX_W-1:0] req_q;
    logic [MAX_W-1:0] mask_q;
    logic             nmi_flag_q;
    exc_code_t        code_w;
    logic             unused_hi;

    // Width and access qualification.
    always_comb begin
        wide_sel = cfg_arch_wide && cfg_wide_default;
        size_ok  = (bus_size == SIZE_W'(ACC_BYTES));
        wr_hit   = bus_wr_en && size_ok;
    end

    // Data bits above the index are not decoded.
    assign unused_hi = ^bus_wdata[DATA_W-1:IDX_W];

    ext_irq_bitsel #(
        .MAX_W    (MAX_W),
        .NARROW_W (NARROW_W),
        .IDX_SRC  (IDX_W)
    ) u_bitsel (
        .wide_sel (wide_sel),
        .wr_hit   (wr_hit),
        .wr_low   (bus_wdata[IDX_W-1:0]),
        .alarm    (tmr_alarm),
        .set_vec  (set_vec)
    );

    ext_irq_reqreg #(
        .MAX_W (MAX_W)
    ) u_reqreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_en     (cpu_clr_en),
        .clr_mask   (cpu_clr_mask),
        .mask_we    (cpu_mask_we),
        .mask_wdata (cpu_mask_wdata),
        .req_q      (req_q),
        .mask_q     (mask_q),
        .pending    (irq_pending)
    );

    ext_irq_arb #(
        .MAX_W (MAX_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll       (cpu_poll),
        .nmi_req    (nmi_req),
        .ien        (psw_ien),
        .req        (req_q),
        .mask       (mask_q),
        .nmi_flag_q (nmi_flag_q),
        .take_valid (take_valid),
        .take_code  (code_w)
    );

    assign take_code = code_w;

    // Bus read returns the request word only on a valid-size read.
    assign bus_rdata = (bus_rd_en && size_ok) ? req_q : '0;

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Module: ext_irq_ctrl_chk
// Checker bound into ext_irq_ctrl; observes ports and stored state.
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int MAX_W     = 64,
    parameter int NARROW_W  = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int ACC_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_sel,
    input logic              bus_wr_en,
    input logic [SIZE_W-1:0] bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tmr_alarm,
    input logic              cpu_clr_en,
    input logic [MAX_W-1:0]  cpu_clr_mask,
    input logic              psw_ien,
    input logic              nmi_req,
    input logic              cpu_poll,
    input logic              irq_pending,
    input logic              take_valid,
    input logic [5:0]        take_code,
    input logic [MAX_W-1:0]  req,
    input logic              nmi_flag
);

    logic size_ok;
    assign size_ok = (bus_size == SIZE_W'(ACC_BYTES));

    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (req == '0 && !take_valid && !nmi_flag));

    a_r4_bad_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !size_ok && !tmr_alarm && !cpu_clr_en) |=> $stable(req));

    a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr_en && !bus_wr_en && !tmr_alarm)
            |=> ((req & $past(cpu_clr_mask)) == '0));

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && size_ok && !wide_sel && (bus_wdata % NARROW_W) == 0)
            |=> req[NARROW_W-1]);

    a_r7_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr_en && cpu_clr_mask == '1 && !bus_wr_en && !tmr_alarm)
            |=> !irq_pending);

    a_r9_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_poll && !nmi_flag && !psw_ien) |=> !take_valid);

    a_r10_toc_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_poll && nmi_flag) |=> (take_valid && take_code == EXC_XFER_CTL));

    a_r10_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_poll && nmi_flag && !nmi_req) |=> !nmi_flag);

    a_r11_take_needs_poll: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> $past(cpu_poll));

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
    .MAX_W     (MAX_W),
    .NARROW_W  (NARROW_W),
    .DATA_W    (DATA_W),
    .SIZE_W    (SIZE_W),
    .ACC_BYTES (ACC_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_sel     (wide_sel),
    .bus_wr_en    (bus_wr_en),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .tmr_alarm    (tmr_alarm),
    .cpu_clr_en   (cpu_clr_en),
    .cpu_clr_mask (cpu_clr_mask),
    .psw_ien      (psw_ien),
    .nmi_req      (nmi_req),
    .cpu_poll     (cpu_poll),
    .irq_pending  (irq_pending),
    .take_valid   (take_valid),
    .take_code    (take_code),
    .req          (req_q),
    .nmi_flag     (nmi_flag_q)
);

// File: tb/ext_irq_ctrl_test.sv
// Bench for ext_irq_ctrl: directed corner cases plus seeded random traffic,
// compared each cycle against a behavioural model kept in the bench.
module ext_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] CODE_EXT = 6'd4;
    localparam logic [5:0] CODE_TOC = 6'd33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_arch_wide = 1'b0, cfg_wide_default = 1'b0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [3:0]  bus_size = 4'd4;
    logic [31:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        tmr_alarm = 1'b0;
    logic        cpu_clr_en = 1'b0;
    logic [63:0] cpu_clr_mask = '0;
    logic        cpu_mask_we = 1'b0;
    logic [63:0] cpu_mask_wdata = '0;
    logic        psw_ien = 1'b0, nmi_req = 1'b0, cpu_poll = 1'b0;
    logic        irq_pending, take_valid;
    logic [5:0]  take_code;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] m_req = '0, m_mask = '0;
    logic        m_nmi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_arch_wide(cfg_arch_wide), .cfg_wide_default(cfg_wide_default),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_alarm(tmr_alarm), .cpu_clr_en(cpu_clr_en), .cpu_clr_mask(cpu_clr_mask),
        .cpu_mask_we(cpu_mask_we), .cpu_mask_wdata(cpu_mask_wdata),
        .psw_ien(psw_ien), .nmi_req(nmi_req), .cpu_poll(cpu_poll),
        .irq_pending(irq_pending), .take_valid(take_valid), .take_code(take_code)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Set vector from R2, R3, R4 and R8.
    function automatic logic [63:0] model_set(logic wr, logic [3:0] sz, logic [31:0] d,
                                              logic al, logic a2, logic wd);
        logic [63:0] v = '0;
        int m = (a2 && wd) ? 63 : 31;
        if (wr && sz == 4'd4) v[int'((~d) & 32'(m))] = 1'b1;
        if (al) v[m] = 1'b1;
        return v;
    endfunction

    // One clock with the currently driven inputs; model update and checks.
    task automatic tick();
        logic        exp_tv = 1'b0;
        logic [5:0]  exp_code = '0;
        logic [63:0] nreq;
        string       ttag = "R11";
        if (cpu_poll) begin
            if (m_nmi) begin exp_tv = 1'b1; exp_code = CODE_TOC; ttag = "R10"; end
            else begin
                ttag = "R9";
                if (psw_ien && |(m_req & m_mask)) begin exp_tv = 1'b1; exp_code = CODE_EXT; end
            end
        end
        nreq = m_req;
        if (cpu_clr_en) nreq = nreq & ~cpu_clr_mask;   // R6: clear before set
        nreq = nreq | model_set(bus_wr_en, bus_size, bus_wdata, tmr_alarm,
                                cfg_arch_wide, cfg_wide_default);
        @(posedge clk);
        @(negedge clk);
        m_req  = nreq;
        if (cpu_mask_we) m_mask = cpu_mask_wdata;
        m_nmi  = nmi_req | (m_nmi & ~cpu_poll);
        check({ttag, " take_valid"}, 64'(take_valid), 64'(exp_tv));
        check({ttag, " take_code"}, 64'(take_code), 64'(exp_code));
        check("R7 irq_pending", 64'(irq_pending), 64'(m_req != '0));
        check("R4 bus_rdata", bus_rdata, (bus_rd_en && bus_size == 4'd4) ? m_req : 64'h0);
    endtask

    task automatic idle();
        bus_wr_en = 0; bus_rd_en = 1; bus_size = 4'd4; bus_wdata = '0;
        tmr_alarm = 0; cpu_clr_en = 0; cpu_clr_mask = '0;
        cpu_mask_we = 0; nmi_req = 0; cpu_poll = 0;
    endtask

    task automatic bus_set(logic [31:0] d);
        idle(); bus_wr_en = 1; bus_wdata = d; tick(); idle();
    endtask

    task automatic clear_all();
        idle(); cpu_clr_en = 1; cpu_clr_mask = '1; tick(); idle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 take_valid", 64'(take_valid), 64'h0);
        check("R1 irq_pending", 64'(irq_pending), 64'h0);
        check("R1 request word", bus_rdata, 64'h0);
        rst_n = 1;
        tick();
        // R1: mask reset to zero - a request with ien and poll must not be taken.
        bus_set(32'd0); psw_ien = 1; cpu_poll = 1; tick(); idle();
        check("R1 mask zero no take", 64'(take_valid), 64'h0);
        clear_all();

        // R2: narrow decoding.
        bus_set(32'd0);  check("R2 data0 narrow", bus_rdata, 64'h0000_0000_8000_0000);
        clear_all();     check("R5 clear all", bus_rdata, 64'h0);
        bus_set(32'd5);  check("R2 data5 narrow", bus_rdata, 64'h0000_0000_0400_0000);
        clear_all();
        bus_set(32'd37); check("R2 data37 wraps", bus_rdata, 64'h0000_0000_0400_0000);
        clear_all();

        // R3: width selection.
        cfg_arch_wide = 1; cfg_wide_default = 1;
        bus_set(32'd0);  check("R3 wide data0", bus_rdata, 64'h8000_0000_0000_0000);
        bus_set(32'd1);  check("R3 wide data1", bus_rdata, 64'hC000_0000_0000_0000);
        clear_all();
        cfg_wide_default = 0;
        bus_set(32'd0);  check("R3 arch only narrow", bus_rdata, 64'h0000_0000_8000_0000);
        clear_all();
        cfg_arch_wide = 0; cfg_wide_default = 1;
        bus_set(32'd0);  check("R3 default only narrow", bus_rdata, 64'h0000_0000_8000_0000);
        clear_all();
        cfg_wide_default = 0;

        // R4: size filter.
        idle(); bus_wr_en = 1; bus_size = 4'd2; tick(); idle();
        check("R4 size2 write ignored", bus_rdata, 64'h0);
        bus_set(32'd0);
        idle(); bus_size = 4'd8; #1;
        check("R4 size8 read zero", bus_rdata, 64'h0);
        idle();

        // R5: partial clear.
        bus_set(32'd5);
        idle(); cpu_clr_en = 1; cpu_clr_mask = 64'h0400_0000; tick(); idle();
        check("R5 partial clear", bus_rdata, 64'h0000_0000_8000_0000);

        // R6: same-cycle clear and set of bit 31.
        idle(); cpu_clr_en = 1; cpu_clr_mask = 64'h8000_0000; bus_wr_en = 1; bus_wdata = 32'd0;
        tick(); idle();
        check("R6 set survives clear", bus_rdata, 64'h0000_0000_8000_0000);
        clear_all();

        // R8: alarm.
        idle(); tmr_alarm = 1; tick(); idle();
        check("R8 alarm narrow", bus_rdata, 64'h0000_0000_8000_0000);
        clear_all();
        idle(); tmr_alarm = 1; bus_wr_en = 1; bus_wdata = 32'd3; tick(); idle();
        check("R8 alarm plus write", bus_rdata, 64'h0000_0000_9000_0000);
        check("R7 pending after set", 64'(irq_pending), 64'h1);
        clear_all();
        check("R7 pending after clear", 64'(irq_pending), 64'h0);

        // R9: maskable take.
        bus_set(32'd0);
        psw_ien = 1; cpu_poll = 1; tick(); idle();
        check("R9 masked off", 64'(take_valid), 64'h0);
        cpu_mask_we = 1; cpu_mask_wdata = 64'h8000_0000; tick(); idle();
        cpu_poll = 1; tick(); idle();
        check("R9 take ext", {57'h0, take_valid, take_code}, {57'h0, 1'b1, CODE_EXT});
        psw_ien = 0; cpu_poll = 1; tick(); idle();
        check("R9 ien low", 64'(take_valid), 64'h0);

        // R11: no poll, no take.
        psw_ien = 1; tick();
        check("R11 no poll", 64'(take_valid), 64'h0);

        // R10: non-maskable priority and flag clearing.
        psw_ien = 0; nmi_req = 1; tick(); idle();
        cpu_poll = 1; tick(); idle();
        check("R10 toc taken", {57'h0, take_valid, take_code}, {57'h0, 1'b1, CODE_TOC});
        cpu_poll = 1; tick(); idle();
        check("R10 flag cleared", 64'(take_valid), 64'h0);
        psw_ien = 1; nmi_req = 1; tick(); idle();
        cpu_poll = 1; tick(); idle();
        check("R10 toc before ext", 64'(take_code), 64'(CODE_TOC));
        tick();
        check("R11 single pulse", 64'(take_valid), 64'h0);

        // Random traffic, checked against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] r = 4'($urandom_range(0, 15));
            bus_wr_en        = ($urandom_range(0, 3) == 0);
            bus_rd_en        = ($urandom_range(0, 1) == 0);
            bus_size         = (r == 0) ? 4'd2 : (r == 1) ? 4'd8 : 4'd4;
            bus_wdata        = $urandom();
            tmr_alarm        = ($urandom_range(0, 15) == 0);
            cpu_clr_en       = ($urandom_range(0, 5) == 0);
            cpu_clr_mask     = {$urandom(), $urandom()};
            cpu_mask_we      = ($urandom_range(0, 15) == 0);
            cpu_mask_wdata   = {$urandom(), $urandom()};
            psw_ien          = ($urandom_range(0, 3) != 0);
            nmi_req          = ($urandom_range(0, 20) == 0);
            cpu_poll         = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 200) == 0) begin
                cfg_arch_wide    = 1'($urandom_range(0, 1));
                cfg_wide_default = 1'($urandom_range(0, 1));
            end
            tick();
        end
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule